// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Data Memory

This block is the data store behind the load/store stage of a small processor. Each request carries a base register value, a signed 16-bit displacement, an access kind and store data. The block forms the effective address itself by adding the sign-extended displacement to the base. It then reads or writes its internal array. Full 32-bit words and single bytes share the same storage, and bytes inside a word are ordered big-endian.

Stores take effect on the clock edge that samples the request. Load results and the misalignment flag come from registers and appear in the cycle after the request. A word access whose effective address is not a multiple of four is refused: the flag rises, the array is not written, and the load output keeps its old value. The array depth is a parameter, and effective-address bits above the array's range are ignored, so the address space wraps onto the array.

Top module: `be_data_mem`

## Requirements
- R1: The effective address is `base_i` plus `disp_i` sign-extended to 32 bits, taken modulo 2^32. Only its low log2(DEPTH_WORDS)+2 bits select a byte, and higher bits are ignored.
- R2: Bytes are ordered big-endian. For a word at aligned address A, byte A holds bits 31:24, A+1 holds 23:16, A+2 holds 15:8 and A+3 holds 7:0.
- R3: A store word (kind 2'b01) to an aligned address writes all four bytes on the rising edge that samples the request.
- R4: A store byte (kind 2'b11) writes `wdata_i[7:0]` to the addressed byte only, and the other three bytes of that word keep their values.
- R5: A load word (kind 2'b00) to an aligned address puts the stored word on `rdata_o` one cycle after the request.
- R6: A load byte (kind 2'b10) puts the addressed byte, sign-extended from bit 7 to 32 bits, on `rdata_o` one cycle after the request.
- R7: A word access (kind bit 1 = 0) whose effective address has nonzero bits 1:0 drives `misalign_o` high in the next cycle. Such a store writes nothing, and such a load leaves `rdata_o` unchanged.
- R8: In every other case `misalign_o` is low in the next cycle. `rdata_o` changes only after a load that was accepted.
- R9: While reset is asserted, `rdata_o` is zero and `misalign_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, sampled each rising edge |
| kind_i | input | 2 | Access kind: 00 load word, 01 store word, 10 load byte, 11 store byte |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| wdata_i | input | 32 | Store data (bits 7:0 for byte stores) |
| rdata_o | output | 32 | Registered load result |
| misalign_o | output | 1 | Registered misaligned-word-access flag |

## Verification
A store changes the array on the same rising edge that samples it. It is seen through a load issued in any later cycle. Load data and the misalignment flag are both due exactly one edge after the request edge. The bench drives each request on a falling edge. It lets one rising edge pass, updates a behavioural byte-array model, and compares both outputs on the next falling edge, so every comparison lands in the cycle where the result is due. Idle cycles and stores are compared the same way, which confirms that `rdata_o` holds and the flag drops.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;
  typedef enum logic [1:0] {
    ACC_LW = 2'b00,
    ACC_SW = 2'b01,
    ACC_LB = 2'b10,
    ACC_SB = 2'b11
  } acc_kind_e;

  localparam int BYTE_W     = 8;
  localparam int WORD_LANES = 4;
  localparam int WORD_W     = BYTE_W * WORD_LANES;
endpackage

// File: rtl/be_addr_gen.sv
module be_addr_gen
  import be_mem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int LOC_W  = 8
) (
  input  logic              req,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [LOC_W-1:0]  loc,
  output logic              byte_acc,
  output logic              bad,
  output logic              st_ok,
  output logic              ld_ok
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] ea;
  logic              ea_hi_unused;
  logic              is_store;

  always_comb begin
    ea       = base + {{EXT_W{disp[DISP_W-1]}}, disp};
    byte_acc = kind[1];
    is_store = kind[0];
    bad      = req && !byte_acc && (ea[1:0] != 2'b00);
    st_ok    = req && is_store && !bad;
    ld_ok    = req && !is_store && !bad;
  end

  assign loc          = ea[LOC_W-1:0];
  assign ea_hi_unused = ^ea[ADDR_W-1:LOC_W];
endmodule

// File: rtl/be_lane_ctrl.sv
module be_lane_ctrl
  import be_mem_pkg::*;
(
  input  logic                               st_ok,
  input  logic                               byte_acc,
  input  logic [1:0]                         off,
  input  logic [WORD_W-1:0]                  wdata,
  output logic [WORD_LANES-1:0]              lane_we,
  output logic [WORD_LANES-1:0][BYTE_W-1:0]  lane_wd
);
  for (genvar g = 0; g < WORD_LANES; g++) begin : g_lane
    always_comb begin
      if (byte_acc) begin
        lane_wd[g] = wdata[BYTE_W-1:0];
        lane_we[g] = st_ok && (off == 2'(g));
      end else begin
        lane_wd[g] = wdata[WORD_W-1-g*BYTE_W -: BYTE_W];
        lane_we[g] = st_ok;
      end
    end
  end
endmodule

// File: rtl/be_mem_array.sv
module be_mem_array
  import be_mem_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  parameter int IDX_W       = 6
) (
  input  logic                               clk,
  input  logic [IDX_W-1:0]                   idx,
  input  logic [WORD_LANES-1:0]              lane_we,
  input  logic [WORD_LANES-1:0][BYTE_W-1:0]  lane_wd,
  output logic [WORD_LANES-1:0][BYTE_W-1:0]  lane_rd
);
  for (genvar g = 0; g < WORD_LANES; g++) begin : g_bank
    logic [BYTE_W-1:0] bank [DEPTH_WORDS];

    always_ff @(posedge clk) begin
      if (lane_we[g]) begin
        bank[idx] <= lane_wd[g];
      end
    end

    assign lane_rd[g] = bank[idx];
  end
endmodule

// File: rtl/be_load_fmt.sv
module be_load_fmt
  import be_mem_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ld_ok,
  input  logic                               byte_acc,
  input  logic                               bad,
  input  logic [1:0]                         off,
  input  logic [WORD_LANES-1:0][BYTE_W-1:0]  lane_rd,
  output logic [WORD_W-1:0]                  rdata,
  output logic                               misalign
);
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              mis_q, mis_d;
  logic [BYTE_W-1:0] sel_byte;
  logic [WORD_W-1:0] word_be;

  always_comb begin
    sel_byte = lane_rd[off];
    for (int i = 0; i < WORD_LANES; i++) begin
      word_be[WORD_W-1-i*BYTE_W -: BYTE_W] = lane_rd[i];
    end
    if (byte_acc) begin
      rdata_d = {{(WORD_W-BYTE_W){sel_byte[BYTE_W-1]}}, sel_byte};
    end else begin
      rdata_d = word_be;
    end
    mis_d = bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (ld_ok) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_q <= 1'b0;
    end else begin
      mis_q <= mis_d;
    end
  end

  assign rdata    = rdata_q;
  assign misalign = mis_q;
endmodule

// File: rtl/be_data_mem.sv
module be_data_mem
  import be_mem_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  parameter int ADDR_W      = 32,
  parameter int DISP_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              misalign_o
);
  localparam int IDX_W = $clog2(DEPTH_WORDS);
  localparam int LOC_W = IDX_W + 2;

  logic [LOC_W-1:0]                  loc;
  logic                              byte_acc, bad, st_ok, ld_ok;
  logic [WORD_LANES-1:0]             lane_we;
  logic [WORD_LANES-1:0][BYTE_W-1:0] lane_wd, lane_rd;

  be_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .LOC_W(LOC_W)) u_addr (
    .req(req_i), .kind(kind_i), .base(base_i), .disp(disp_i),
    .loc(loc), .byte_acc(byte_acc), .bad(bad), .st_ok(st_ok), .ld_ok(ld_ok)
  );

  be_lane_ctrl u_lane (
    .st_ok(st_ok), .byte_acc(byte_acc), .off(loc[1:0]), .wdata(wdata_i),
    .lane_we(lane_we), .lane_wd(lane_wd)
  );

  be_mem_array #(.DEPTH_WORDS(DEPTH_WORDS), .IDX_W(IDX_W)) u_array (
    .clk(clk), .idx(loc[LOC_W-1:2]), .lane_we(lane_we), .lane_wd(lane_wd),
    .lane_rd(lane_rd)
  );

  be_load_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .ld_ok(ld_ok), .byte_acc(byte_acc), .bad(bad),
    .off(loc[1:0]), .lane_rd(lane_rd), .rdata(rdata_o), .misalign(misalign_o)
  );
endmodule

// File: rtl/be_data_mem_chk.sv
module be_data_mem_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic [1:0]  kind_i,
  input logic [1:0]  base_lo,
  input logic [1:0]  disp_lo,
  input logic [31:0] rdata_o,
  input logic        misalign_o
);
  logic [1:0] ea_lo;
  logic       word_bad;

  assign ea_lo    = base_lo + disp_lo;
  assign word_bad = req_i && !kind_i[1] && (ea_lo != 2'b00);

  // R7: misaligned word access raises the flag next cycle
  a_r7_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
    word_bad |=> misalign_o);

  // R7: misaligned load leaves the load output untouched
  a_r7_bad_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (word_bad && !kind_i[0]) |=> $stable(rdata_o));

  // R8: flag low after any other cycle
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !word_bad |=> !misalign_o);

  // R8: no load, no change on the load output
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_i || kind_i[0]) |=> $stable(rdata_o));

  // R6: byte load result is sign-extended
  a_r6_byte_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && kind_i == 2'b10) |=> (rdata_o[31:7] == '0 || rdata_o[31:7] == '1));

  // R9: outputs at their reset values while reset is held
  always_comb begin
    if (!rst_n) begin
      a_r9_reset_vals: assert (rdata_o == '0 && !misalign_o);
    end
  end
endmodule

bind be_data_mem be_data_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i),
  .base_lo(base_i[1:0]), .disp_lo(disp_i[1:0]),
  .rdata_o(rdata_o), .misalign_o(misalign_o)
);

// File: tb/tb_be_data_mem.sv
`timescale 1ns/1ps
module tb_be_data_mem;
  localparam int DEPTH = 64;
  localparam int NB    = DEPTH * 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [1:0]  kind_i;
  logic [31:0] base_i;
  logic [15:0] disp_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        misalign_o;

  int checks = 0;
  int failures = 0;

  logic [7:0]  mdl [NB];
  logic [31:0] exp_rd;
  logic        exp_mis;

  always #4 clk = ~clk;

  be_data_mem #(.DEPTH_WORDS(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i),
    .base_i(base_i), .disp_i(disp_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .misalign_o(misalign_o)
  );

  task automatic compare(input string tag);
    checks++;
    if (rdata_o !== exp_rd) begin
      failures++;
      $display("FAIL %s rdata_o actual=%h expected=%h", tag, rdata_o, exp_rd);
    end
    checks++;
    if (misalign_o !== exp_mis) begin
      failures++;
      $display("FAIL %s misalign_o actual=%b expected=%b", tag, misalign_o, exp_mis);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, model, compare.
  task automatic cyc(input logic r, input logic [1:0] k, input logic [31:0] b,
                     input logic [15:0] d, input logic [31:0] w, input string tag);
    logic [31:0] ea;
    int a;
    req_i = r; kind_i = k; base_i = b; disp_i = d; wdata_i = w;
    @(posedge clk);
    ea = b + {{16{d[15]}}, d};
    a = int'(ea % NB);
    exp_mis = r && !k[1] && (ea[1:0] != 2'b00);
    if (r && !exp_mis) begin
      case (k)
        2'b01: begin
          mdl[a] = w[31:24]; mdl[a+1] = w[23:16]; mdl[a+2] = w[15:8]; mdl[a+3] = w[7:0];
        end
        2'b11: mdl[a] = w[7:0];
        2'b00: exp_rd = {mdl[a], mdl[a+1], mdl[a+2], mdl[a+3]};
        default: exp_rd = {{24{mdl[a][7]}}, mdl[a]};
      endcase
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; kind_i = 2'b00; base_i = '0; disp_i = '0; wdata_i = '0;
    exp_rd = '0; exp_mis = 1'b0;
    repeat (3) @(negedge clk);
    compare("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9 after release");

    // R1 negative displacement, R3 word store
    cyc(1, 2'b01, 32'h0000_0100, 16'hFF08, 32'h1122_3344, "R1 R3 store neg disp");
    cyc(1, 2'b00, 32'h0000_0000, 16'h0008, 32'h0, "R5 load word");
    // R2 byte order
    cyc(1, 2'b10, 32'h0000_0008, 16'h0000, 32'h0, "R2 byte0 msb");
    cyc(1, 2'b10, 32'h0000_0008, 16'h0003, 32'h0, "R2 byte3 lsb");
    cyc(1, 2'b10, 32'h0000_000A, 16'h0000, 32'h0, "R2 byte2");
    // R1 upper address bits ignored
    cyc(1, 2'b01, 32'h4000_0020, 16'h0000, 32'hA0B1_C2D3, "R1 alias store");
    cyc(1, 2'b00, 32'h0000_0020, 16'h0000, 32'h0, "R1 alias load");
    cyc(1, 2'b10, 32'h0000_0020, 16'h0000, 32'h0, "R6 negative byte");
    cyc(1, 2'b10, 32'h0000_0008, 16'h0001, 32'h0, "R6 positive byte");
    // R4 byte store keeps neighbours
    cyc(1, 2'b11, 32'h0000_0022, 16'h0000, 32'h1234_56EE, "R4 store byte");
    cyc(1, 2'b00, 32'h0000_0020, 16'h0000, 32'h0, "R4 word after byte store");
    cyc(1, 2'b11, 32'h0000_0030, 16'hFFF3, 32'hFFFF_FF5A, "R4 byte store neg disp");
    cyc(1, 2'b00, 32'h0000_0020, 16'h0000, 32'h0, "R4 lane3 byte store");
    // R7 misaligned store refused, misaligned load holds
    cyc(1, 2'b01, 32'h0000_0021, 16'h0000, 32'h0000_0000, "R7 bad store flag");
    cyc(1, 2'b00, 32'h0000_0020, 16'h0000, 32'h0, "R7 memory unchanged");
    cyc(1, 2'b00, 32'h0000_0008, 16'h0002, 32'h0, "R7 bad load hold");
    cyc(1, 2'b01, 32'h0000_0003, 16'h0005, 32'hDEAD_BEEF, "R7 sum aligned store ok");
    cyc(1, 2'b00, 32'h0000_0008, 16'h0000, 32'h0, "R7 sum aligned load");
    // R8 idle and store cycles
    cyc(0, 2'b00, 32'h0000_0020, 16'h0000, 32'h0, "R8 idle");
    cyc(0, 2'b01, 32'h0000_0021, 16'h0000, 32'h0, "R8 idle no flag");
    cyc(1, 2'b01, 32'h0000_0040, 16'h0000, 32'h0102_0304, "R8 store keeps rdata");
    cyc(1, 2'b11, 32'h0000_0041, 16'h0000, 32'h0000_0099, "R8 byte store keeps rdata");
    cyc(1, 2'b00, 32'h0000_0040, 16'h0000, 32'h0, "R4 R5 word readback");
    // R1 wrap at max positive displacement
    cyc(1, 2'b01, 32'h0000_0001, 16'h7FFF, 32'h5566_7788, "R1 max disp store");
    cyc(1, 2'b00, 32'h0000_0000, 16'h0000, 32'h0, "R1 max disp wraps");

    // R3 R5 sweep of words, then R6 byte reads
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, 2'b01, 32'(i * 4), 16'h0000, 32'h8F00_0000 ^ (32'(i) * 32'h0101_0307), "R3 sweep store");
    end
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, 2'b00, 32'h0000_1000, 16'(i * 4), 32'h0, "R5 sweep load");
      cyc(1, 2'b10, 32'(i * 4 + 1), 16'hFFFF, 32'h0, "R6 sweep byte");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule